// File: doc/BRIEF.md
# Power-Management Event Status and Routing

This block keeps four power-management event flags and turns them into interrupt or wake requests. Three inputs raise the flags. The first is an active-low power button, which is synchronised on chip. The second is a free-running power-management timer, whose flag rises each time a selected bit of the timer goes high. The third is a strobe from firmware that asks the operating-system handler for attention. Software clears a flag by writing a one to it.

The interrupt and wake outputs are levels. While the system is working, each flag whose enable is set drives either the SCI output or the SMI output, chosen by an SCI-select input. While the system sleeps, the button flag drives the wake output instead. If the button is held for a programmed number of tick pulses, the block drops the button flag and raises an override flag. It also emits a one-cycle soft-off request and keeps the button armed as a wake source.

The button flag has its own reset input. This lets it survive the chip-level hard reset that clears everything else.

Top module: `pm_evt_status`

## Requirements
- R1: All flags are write-one-to-clear. When `clr_i` is high, each bit of `clr_mask_i` that is 1 clears the matching bit of `status_o` at the next clock edge. A 0 in the mask leaves that bit unchanged. The bit positions in `status_o` are: bit 0 timer overflow, bit 1 firmware attention, bit 2 button, bit 3 button override.
- R2: A high-to-low transition on `pwrbtn_ni` sets status bit 2 within four clock cycles. The enable inputs have no effect on this.
- R3: The button may stay low while `HOLD_TICKS` pulses of `tick_i` are counted. On the edge that takes the count to its limit, status bit 2 clears and status bit 3 sets, and `soft_off_o` is high for exactly one cycle. This happens once per press.
- R4: `rst_ni` clears every flag except bit 2. Only `resume_rst_ni` clears bit 2.
- R5: When `sleep_st_i` is 0, let a pending event be (bit 2 AND `btn_en_i`) OR (bit 0 AND `tmr_en_i`). `sci_o` is high when a pending event exists and `sci_en_i` is 1. `smi_o` is high when a pending event exists and `sci_en_i` is 0.
- R6: When `sleep_st_i` is nonzero (S1 to S5), `sci_o` and `smi_o` are low. `wake_o` is high when bit 2 is set and either `btn_en_i` or bit 3 is set. `wake_o` is always low when `sleep_st_i` is 0.
- R7: A high `fw_rel_i` sets bit 1. In the working state, bit 1 drives `sci_o` regardless of `sci_en_i`.
- R8: Bit 0 sets on each rising transition of bit `TMR_BIT` of `pm_tmr_i`. It does not set again while that bit stays high. With `tmr_en_i` low, bit 0 raises no interrupt.
- R9: When a hardware set and a software clear hit the same bit in the same cycle, the set wins.
- R10: The hold count restarts whenever the synchronised button returns high. Two short presses that together exceed `HOLD_TICKS` do not set the override.
- R11: The interrupt and wake outputs are levels. They fall in the cycle after the clear that removes their last enabled flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Hard reset, active low, asynchronous |
| resume_rst_ni | input | 1 | Reset for the button flag only, active low |
| pwrbtn_ni | input | 1 | Power button, active low, asynchronous |
| tick_i | input | 1 | Time base for the hold counter |
| pm_tmr_i | input | TMR_W | Free-running power-management timer |
| fw_rel_i | input | 1 | Firmware attention strobe |
| sci_en_i | input | 1 | 1 routes events to SCI, 0 routes them to SMI |
| btn_en_i | input | 1 | Button event enable |
| tmr_en_i | input | 1 | Timer overflow enable |
| sleep_st_i | input | 3 | Sleep state, 0 = working, 1 to 5 = S1 to S5 |
| clr_i | input | 1 | Clear write strobe |
| clr_mask_i | input | 4 | Write-one-to-clear data |
| status_o | output | 4 | Flags {override, button, firmware, timer} |
| sci_o | output | 1 | SCI request level |
| smi_o | output | 1 | SMI request level |
| wake_o | output | 1 | Wake request level |
| soft_off_o | output | 1 | One-cycle soft-off request |

## Verification
A flag that is set or cleared wrongly shows up on `status_o` at the next edge. The request outputs show the fault in the same cycle, because they are decoded without a register from the flags. A fault in the button synchroniser or the hold counter only becomes visible after the synchroniser latency or the full tick count. For that reason the long-press and restart cases are run with a small `HOLD_TICKS`, and the results are checked a few cycles after each press ends. Routing errors are found by sweeping the sleep state and both enable polarities against a model of the flags.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int unsigned NUM_STS = 4;
  localparam int unsigned STS_TMR = 0;
  localparam int unsigned STS_GLB = 1;
  localparam int unsigned STS_BTN = 2;
  localparam int unsigned STS_OVR = 3;
  localparam int unsigned SLP_W   = 3;
  localparam logic [SLP_W-1:0] SLP_WORKING = '0;
endpackage

// File: rtl/pm_btn_monitor.sv
module pm_btn_monitor #(
  parameter int unsigned HOLD_TICKS = 4096,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwrbtn_ni,
  input  logic tick_i,
  output logic press_o,
  output logic long_press_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lvl_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   fired_q;
  logic                   btn_low;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      lvl_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pwrbtn_ni};
      lvl_q  <= sync_q[SYNC_STAGES-1];
    end
  end

  assign btn_low = ~sync_q[SYNC_STAGES-1];
  assign press_o = btn_low & lvl_q;

  // hold counter restarts on release, fires once per press
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (!btn_low) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (tick_i && !fired_q) begin
      if (cnt_q == CNT_W'(HOLD_TICKS - 1)) fired_q <= 1'b1;
      else                                 cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign long_press_o = btn_low & tick_i & ~fired_q & (cnt_q == CNT_W'(HOLD_TICKS - 1));
endmodule

// File: rtl/pm_tmr_ovf_det.sv
module pm_tmr_ovf_det #(
  parameter int unsigned TMR_W   = 24,
  parameter int unsigned TMR_BIT = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TMR_W-1:0] pm_tmr_i,
  output logic             rise_o
);
  logic bit_q;
  logic primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q    <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      bit_q    <= pm_tmr_i[TMR_BIT];
      primed_q <= 1'b1;
    end
  end

  assign rise_o = primed_q & pm_tmr_i[TMR_BIT] & ~bit_q;
endmodule

// File: rtl/pm_evt_router.sv
module pm_evt_router
  import pm_evt_pkg::*;
(
  input  logic               sci_en_i,
  input  logic               btn_en_i,
  input  logic               tmr_en_i,
  input  logic [SLP_W-1:0]   sleep_st_i,
  input  logic [NUM_STS-1:0] sts_i,
  output logic               sci_o,
  output logic               smi_o,
  output logic               wake_o
);
  logic working;
  logic pend;

  always_comb begin
    working = (sleep_st_i == SLP_WORKING);
    pend    = (sts_i[STS_BTN] & btn_en_i) | (sts_i[STS_TMR] & tmr_en_i);
    sci_o   = working & (sts_i[STS_GLB] | (pend & sci_en_i));
    smi_o   = working & pend & ~sci_en_i;
    // override keeps the button armed for wake
    wake_o  = ~working & sts_i[STS_BTN] & (btn_en_i | sts_i[STS_OVR]);
  end
endmodule

// File: rtl/pm_evt_status.sv
module pm_evt_status
  import pm_evt_pkg::*;
#(
  parameter int unsigned TMR_W      = 24,
  parameter int unsigned TMR_BIT    = 22,
  parameter int unsigned HOLD_TICKS = 4096
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               resume_rst_ni,
  input  logic               pwrbtn_ni,
  input  logic               tick_i,
  input  logic [TMR_W-1:0]   pm_tmr_i,
  input  logic               fw_rel_i,
  input  logic               sci_en_i,
  input  logic               btn_en_i,
  input  logic               tmr_en_i,
  input  logic [SLP_W-1:0]   sleep_st_i,
  input  logic               clr_i,
  input  logic [NUM_STS-1:0] clr_mask_i,
  output logic [NUM_STS-1:0] status_o,
  output logic               sci_o,
  output logic               smi_o,
  output logic               wake_o,
  output logic               soft_off_o
);
  logic press;
  logic long_press;
  logic tmr_rise;
  logic [NUM_STS-1:0] clr;
  logic tmr_q, glb_q, btn_q, ovr_q;

  assign clr = clr_i ? clr_mask_i : '0;

  pm_btn_monitor #(.HOLD_TICKS(HOLD_TICKS), .SYNC_STAGES(2)) u_btn (
    .clk_i, .rst_ni, .pwrbtn_ni, .tick_i,
    .press_o(press), .long_press_o(long_press)
  );

  pm_tmr_ovf_det #(.TMR_W(TMR_W), .TMR_BIT(TMR_BIT)) u_tmr (
    .clk_i, .rst_ni, .pm_tmr_i, .rise_o(tmr_rise)
  );

  // set beats clear on every flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q <= 1'b0;
      glb_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (tmr_rise)              tmr_q <= 1'b1;
      else if (clr[STS_TMR])     tmr_q <= 1'b0;
      if (fw_rel_i)              glb_q <= 1'b1;
      else if (clr[STS_GLB])     glb_q <= 1'b0;
      if (long_press)            ovr_q <= 1'b1;
      else if (clr[STS_OVR])     ovr_q <= 1'b0;
    end
  end

  // separate reset domain: survives hard reset
  always_ff @(posedge clk_i or negedge resume_rst_ni) begin
    if (!resume_rst_ni)          btn_q <= 1'b0;
    else if (long_press)         btn_q <= 1'b0;
    else if (press)              btn_q <= 1'b1;
    else if (clr[STS_BTN])       btn_q <= 1'b0;
  end

  always_comb begin
    status_o          = '0;
    status_o[STS_TMR] = tmr_q;
    status_o[STS_GLB] = glb_q;
    status_o[STS_BTN] = btn_q;
    status_o[STS_OVR] = ovr_q;
  end

  assign soft_off_o = long_press;

  pm_evt_router u_route (
    .sci_en_i, .btn_en_i, .tmr_en_i, .sleep_st_i,
    .sts_i(status_o), .sci_o, .smi_o, .wake_o
  );
endmodule

// File: rtl/pm_evt_status_chk.sv
module pm_evt_status_chk
  import pm_evt_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               resume_rst_ni,
  input logic               fw_rel_i,
  input logic               sci_en_i,
  input logic [SLP_W-1:0]   sleep_st_i,
  input logic               clr_i,
  input logic [NUM_STS-1:0] clr_mask_i,
  input logic [NUM_STS-1:0] status_o,
  input logic               smi_o,
  input logic               wake_o,
  input logic               soft_off_o,
  input logic               tmr_rise
);
  // R5
  smi_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !resume_rst_ni)
    smi_o |-> (!sci_en_i && sleep_st_i == SLP_WORKING));
  // R6
  wake_sleep_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !resume_rst_ni)
    wake_o |-> (sleep_st_i != SLP_WORKING));
  // R3
  long_press_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !resume_rst_ni)
    soft_off_o |=> (status_o[STS_OVR] && !status_o[STS_BTN]));
  // R8
  tmr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !resume_rst_ni)
    tmr_rise |=> status_o[STS_TMR]);
  // R1
  glb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !resume_rst_ni)
    (status_o[STS_GLB] && !(clr_i && clr_mask_i[STS_GLB])) |=> status_o[STS_GLB]);
  // R9
  glb_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !resume_rst_ni)
    fw_rel_i |=> status_o[STS_GLB]);
endmodule

bind pm_evt_status pm_evt_status_chk u_chk (.*);

// File: tb/pm_evt_status_bench.sv
module pm_evt_status_bench;
  localparam int unsigned TMR_W = 24;
  localparam int unsigned TMR_BIT = 22;
  localparam int unsigned HOLD = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0, resume_rst_ni = 1'b0;
  logic pwrbtn_ni = 1'b1, tick_i = 1'b0, fw_rel_i = 1'b0;
  logic [TMR_W-1:0] pm_tmr_i = '0;
  logic sci_en_i = 1'b0, btn_en_i = 1'b0, tmr_en_i = 1'b0;
  logic [2:0] sleep_st_i = '0;
  logic clr_i = 1'b0;
  logic [3:0] clr_mask_i = '0;
  logic [3:0] status_o;
  logic sci_o, smi_o, wake_o, soft_off_o;

  int n_chk = 0, n_bad = 0, n_off = 0;

  always #5 clk = ~clk;

  pm_evt_status #(.TMR_W(TMR_W), .TMR_BIT(TMR_BIT), .HOLD_TICKS(HOLD)) u_pm_evt_status (
    .clk_i(clk), .rst_ni, .resume_rst_ni, .pwrbtn_ni, .tick_i, .pm_tmr_i, .fw_rel_i,
    .sci_en_i, .btn_en_i, .tmr_en_i, .sleep_st_i, .clr_i, .clr_mask_i,
    .status_o, .sci_o, .smi_o, .wake_o, .soft_off_o
  );

  always @(negedge clk) if (soft_off_o) n_off++;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [2:0] route(input logic [3:0] s, input logic [2:0] slp,
                                       input logic se, input logic be, input logic te);
    logic pend, sci, smi, wk;
    pend = (s[2] & be) | (s[0] & te);
    sci  = (slp == 0) & (s[1] | (pend & se));
    smi  = (slp == 0) & pend & ~se;
    wk   = (slp != 0) & s[2] & (be | s[3]);
    return {sci, smi, wk};
  endfunction

  task automatic clear(input logic [3:0] m);
    clr_i = 1'b1; clr_mask_i = m;
    cyc(1);
    clr_i = 1'b0; clr_mask_i = '0;
  endtask

  initial begin
    cyc(3);
    rst_ni = 1'b1; resume_rst_ni = 1'b1;
    cyc(2);
    chk("R4 reset status", status_o, 4'h0);
    chk("R4 reset outputs", {sci_o, smi_o, wake_o, soft_off_o}, 0);

    // button press, routing in S0
    btn_en_i = 1'b1; sci_en_i = 1'b1;
    pwrbtn_ni = 1'b0; cyc(4); pwrbtn_ni = 1'b1; cyc(3);
    chk("R2 press sets btn", status_o, 4'h4);
    chk("R5 sci on btn", {sci_o, smi_o}, 2'b10);
    sci_en_i = 1'b0; cyc(1);
    chk("R5 smi on btn", {sci_o, smi_o}, 2'b01);
    clear(4'h0);
    chk("R1 write zero ignored", status_o, 4'h4);
    clear(4'h4);
    chk("R1 clear btn", status_o, 4'h0);
    chk("R11 smi drops after clear", smi_o, 0);

    // hard reset keeps button flag
    pwrbtn_ni = 1'b0; cyc(4); pwrbtn_ni = 1'b1; cyc(3);
    rst_ni = 1'b0; cyc(2); rst_ni = 1'b1; cyc(2);
    chk("R4 btn survives hard reset", status_o, 4'h4);
    resume_rst_ni = 1'b0; cyc(1); resume_rst_ni = 1'b1; cyc(1);
    chk("R4 resume reset clears btn", status_o, 4'h0);

    // restart of hold count
    pwrbtn_ni = 1'b0; cyc(3); tick_i = 1'b1; cyc(5); tick_i = 1'b0;
    pwrbtn_ni = 1'b1; cyc(4);
    pwrbtn_ni = 1'b0; cyc(3); tick_i = 1'b1; cyc(5); tick_i = 1'b0;
    pwrbtn_ni = 1'b1; cyc(4);
    chk("R10 no override on split presses", status_o[3], 0);
    chk("R10 no soft-off", n_off, 0);
    clear(4'h4);

    // long press
    pwrbtn_ni = 1'b0; cyc(3); tick_i = 1'b1; cyc(HOLD + 6); tick_i = 1'b0;
    chk("R3 override set btn cleared", status_o, 4'h8);
    chk("R3 one soft-off pulse", n_off, 1);
    pwrbtn_ni = 1'b1; cyc(4);

    // sleep routing, override arms button
    btn_en_i = 1'b0; sleep_st_i = 3'd5;
    pwrbtn_ni = 1'b0; cyc(4); pwrbtn_ni = 1'b1; cyc(3);
    chk("R6 wake via override arm", {sci_o, smi_o, wake_o}, 3'b001);
    clear(4'h8); cyc(1);
    chk("R6 no wake without enable", wake_o, 0);
    btn_en_i = 1'b1; cyc(1);
    chk("R6 wake with enable", {sci_o, smi_o, wake_o}, 3'b001);
    clear(4'h4);
    chk("R11 wake drops", wake_o, 0);
    sleep_st_i = 3'd0; btn_en_i = 1'b0;

    // firmware attention
    sci_en_i = 1'b0;
    fw_rel_i = 1'b1; cyc(1); fw_rel_i = 1'b0;
    chk("R7 glb set", status_o, 4'h2);
    chk("R7 sci despite sci_en=0", {sci_o, smi_o}, 2'b10);
    fw_rel_i = 1'b1; clr_i = 1'b1; clr_mask_i = 4'h2; cyc(1);
    fw_rel_i = 1'b0; clr_i = 1'b0; clr_mask_i = '0;
    chk("R9 set beats clear", status_o[1], 1);
    clear(4'h2);
    chk("R11 sci drops", sci_o, 0);

    // timer overflow
    tmr_en_i = 1'b0;
    pm_tmr_i[TMR_BIT] = 1'b1; cyc(2);
    chk("R8 tmr set on rise", status_o, 4'h1);
    chk("R8 no irq when disabled", {sci_o, smi_o}, 2'b00);
    tmr_en_i = 1'b1; cyc(1);
    chk("R5 tmr smi", {sci_o, smi_o}, 2'b01);
    clear(4'h1); cyc(2);
    chk("R8 no reset while bit high", status_o[0], 0);
    pm_tmr_i[TMR_BIT] = 1'b0; cyc(2);

    // random phase against model
    begin
      logic [3:0] m;
      logic prev22;
      void'($urandom(32'h5eed_1234));
      m = status_o;
      prev22 = pm_tmr_i[TMR_BIT];
      for (int it = 0; it < 400; it++) begin
        logic b22, rise;
        logic [3:0] cm;
        pm_tmr_i   = TMR_W'($urandom);
        b22        = ($urandom % 4 == 0) ? ~prev22 : prev22;
        pm_tmr_i[TMR_BIT] = b22;
        sleep_st_i = 3'($urandom % 6);
        sci_en_i   = 1'($urandom);
        btn_en_i   = 1'($urandom);
        tmr_en_i   = 1'($urandom);
        fw_rel_i   = ($urandom % 8 == 0);
        clr_i      = 1'($urandom);
        clr_mask_i = 4'($urandom);
        cm   = clr_i ? clr_mask_i : 4'h0;
        rise = b22 & ~prev22;
        prev22 = b22;
        m[0] = rise ? 1'b1 : (cm[0] ? 1'b0 : m[0]);
        m[1] = fw_rel_i ? 1'b1 : (cm[1] ? 1'b0 : m[1]);
        m[2] = cm[2] ? 1'b0 : m[2];
        m[3] = cm[3] ? 1'b0 : m[3];
        cyc(1);
        chk("R1 R8 R9 random status", status_o, m);
        chk("R5 R6 random routing", {sci_o, smi_o, wake_o},
            route(m, sleep_st_i, sci_en_i, btn_en_i, tmr_en_i));
      end
      clr_i = 1'b0; fw_rel_i = 1'b0;
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule